// File: doc/BRIEF.md
# Blanked Pulse Current Guard

This block sits between the digitized current-sense comparators of a switching regulator and its pulse and fault logic. It receives three inputs: a current-limit trip, an overcurrent trip at a higher level, and the on/dead phase of the switching clock. Every switching cycle begins with a short window in which the switch-on current spike must not be mistaken for a real overload. A blanking timer opens this window at the start of each on-phase and masks both trips while it runs. The timer is held at zero for the whole dead time.

After the window closes, a current-limit trip cuts only the present pulse. It does this with a single-clock terminate strobe, and the next cycle starts normally. An overcurrent trip is treated as a fault. It raises a request toward the soft-start fault sequencer, and the request stays raised until that sequencer acknowledges it. The blanking length is a count of system clocks, captured while reset is held. Blanking can be switched off, and so can the whole block through a static enable.

Top module: `blanked_trip_guard`

## Requirements
- R1: While `rst` is high, every output is driven low and `cfg_blank_len` is captured. Later changes to `cfg_blank_len` have no effect until the next reset.
- R2: The phase is registered from `on_phase`, where 1 means on-phase and 0 means dead time. While the registered phase shows dead time, the blanking timer is held at zero and `blank_active` is low.
- R3: After the edge at which `on_phase` is first sampled high in a cycle, `blank_active` is high for exactly L clocks, where L is the captured length. It then stays low for the rest of that on-phase.
- R4: A trip sampled at an edge while `blank_active` is high is dropped and not remembered.
- R5: A `trip_cl` sampled high while the registered phase is on-phase and `blank_active` is low gives `term_pulse` high for exactly one clock. This happens at most once per on-phase.
- R6: A `trip_oc` sampled under the same conditions sets `fault_req`. `fault_req` stays high until an edge at which `fault_ack` is high and no new accepted overcurrent trip occurs. A new trip wins over a simultaneous acknowledge.
- R7: With `blank_en` low, or with a captured length of 0, `blank_active` never rises and trips are accepted from the first on-phase clock.
- R8: With `enable` low, `fault_req` is cleared, no trip is accepted, and all outputs stay low.
- R9: Trips sampled while the registered phase shows dead time have no effect.
- R10: A current-limit trip and an overcurrent trip accepted at the same edge produce both the terminate strobe and the fault request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Static block enable |
| blank_en | input | 1 | Static blanking enable |
| cfg_blank_len | input | 6 | Blanking length in clocks, captured during reset |
| on_phase | input | 1 | Switching phase: 1 on-phase, 0 dead time |
| trip_cl | input | 1 | Digitized current-limit trip |
| trip_oc | input | 1 | Digitized overcurrent trip |
| fault_ack | input | 1 | Acknowledge from the fault sequencer |
| term_pulse | output | 1 | One-clock strobe ending the present pulse |
| fault_req | output | 1 | Held fault request toward the sequencer |
| blank_active | output | 1 | High while trips are being masked |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the pulse-terminate strobe and the fault request. The bench drives both trips high in the first clock after blanking ends, and both `term_pulse` and `fault_req` must rise together. The second pair is the fault set and the acknowledge. The bench raises a fresh overcurrent trip together with `fault_ack`, and the request must stay high. On the edge after that, an acknowledge alone must clear it.

// File: rtl/blanked_guard_pkg.sv
package blanked_guard_pkg;
  localparam int unsigned BLANK_W_DEF = 6;

  // Saturating increment toward a limit
  function automatic logic [BLANK_W_DEF-1:0] sat_step(
    input logic [BLANK_W_DEF-1:0] v,
    input logic [BLANK_W_DEF-1:0] lim
  );
    return (v == lim) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/blank_window.sv
module blank_window
  import blanked_guard_pkg::*;
#(
  parameter int unsigned W = BLANK_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         blank_en,
  input  logic [W-1:0] cfg_len,
  input  logic         on_phase,
  output logic         phase_on,
  output logic         masking
);
  logic [W-1:0] len_q;
  logic [W-1:0] cnt_q;
  logic         ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= cfg_len;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      ph_q <= on_phase;
      if (!on_phase || !ph_q) cnt_q <= '0;
      else                    cnt_q <= sat_step(cnt_q, len_q);
    end
  end

  assign phase_on = ph_q;
  assign masking  = blank_en && ph_q && (cnt_q != len_q);

  // R2: dead time keeps the timer cleared
  assert_dead_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !ph_q |-> (cnt_q == '0 && !masking));

  // R3: blanking is active on the first on-phase clock when enabled
  assert_blank_start_R3: assert property (@(posedge clk) disable iff (rst)
    (ph_q && !$past(ph_q) && blank_en && len_q != '0) |-> masking);
endmodule

// File: rtl/trip_judge.sv
module trip_judge (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic on_phase,
  input  logic phase_on,
  input  logic masking,
  input  logic trip_cl,
  input  logic trip_oc,
  input  logic fault_ack,
  output logic term_pulse,
  output logic fault_req
);
  logic open_win;
  logic cl_hit;
  logic oc_hit;
  logic ended_q;
  logic term_q;
  logic fault_q;

  always_comb begin
    open_win = enable && phase_on && !masking;
    cl_hit   = open_win && trip_cl && !ended_q;
    oc_hit   = open_win && trip_oc;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      ended_q <= 1'b0;
      term_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      term_q <= cl_hit;
      if (!on_phase) ended_q <= 1'b0;
      else if (cl_hit) ended_q <= 1'b1;
      if (oc_hit)         fault_q <= 1'b1;
      else if (fault_ack) fault_q <= 1'b0;
    end
  end

  assign term_pulse = term_q;
  assign fault_req  = fault_q;

  // R5: the strobe never lasts beyond one clock
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    term_q |=> !term_q);

  // R4: a masked current-limit trip does not end the pulse
  assert_masked_trip_R4: assert property (@(posedge clk) disable iff (rst)
    (masking && !ended_q) |=> !term_q);

  // R6: request held until acknowledged
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !fault_ack && enable) |=> fault_q);

  // R8: disabled block stays quiet
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!term_q && !fault_q));
endmodule

// File: rtl/blanked_trip_guard.sv
module blanked_trip_guard
  import blanked_guard_pkg::*;
#(
  parameter int unsigned BLANK_W = BLANK_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               blank_en,
  input  logic [BLANK_W-1:0] cfg_blank_len,
  input  logic               on_phase,
  input  logic               trip_cl,
  input  logic               trip_oc,
  input  logic               fault_ack,
  output logic               term_pulse,
  output logic               fault_req,
  output logic               blank_active
);
  logic phase_on;
  logic masking;

  blank_window #(.W(BLANK_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .blank_en (blank_en),
    .cfg_len  (cfg_blank_len),
    .on_phase (on_phase),
    .phase_on (phase_on),
    .masking  (masking)
  );

  trip_judge u_judge (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .on_phase   (on_phase),
    .phase_on   (phase_on),
    .masking    (masking),
    .trip_cl    (trip_cl),
    .trip_oc    (trip_oc),
    .fault_ack  (fault_ack),
    .term_pulse (term_pulse),
    .fault_req  (fault_req)
  );

  assign blank_active = masking;

  // R1: outputs low right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!term_pulse && !fault_req && !blank_active));
endmodule

// File: tb/test_blanked_trip_guard.sv
module test_blanked_trip_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic       blank_en = 1'b1;
  logic [5:0] cfg_blank_len = 6'd3;
  logic       on_phase = 1'b0;
  logic       trip_cl = 1'b0;
  logic       trip_oc = 1'b0;
  logic       fault_ack = 1'b0;
  logic       term_pulse, fault_req, blank_active;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  blanked_trip_guard i_blanked_trip_guard (
    .clk(clk), .rst(rst), .enable(enable), .blank_en(blank_en),
    .cfg_blank_len(cfg_blank_len), .on_phase(on_phase),
    .trip_cl(trip_cl), .trip_oc(trip_oc), .fault_ack(fault_ack),
    .term_pulse(term_pulse), .fault_req(fault_req),
    .blank_active(blank_active)
  );

  // Row bits: {on, cl, oc, ack, exp_term, exp_fault, exp_blank}; length 3
  localparam logic [6:0] VEC [18] = '{
    7'b0000_000, // R2 dead time
    7'b1100_001, // R9 trip while phase still dead; R3 blank starts
    7'b1100_001, // R4 cl masked
    7'b1010_001, // R4 oc masked
    7'b1000_000, // R3 blank ended after 3 clocks
    7'b1100_100, // R5 strobe
    7'b1100_000, // R5 once per on-phase
    7'b0100_000, // R9
    7'b0010_000, // R9 oc in dead time
    7'b1000_001, // R3
    7'b1000_001,
    7'b1000_001,
    7'b1000_000,
    7'b1110_110, // R10 both at once
    7'b1000_010, // R6 held
    7'b1001_000, // R6 ack clears
    7'b1011_010, // R6 new trip wins over ack
    7'b0001_000  // R6 ack clears
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic on, input logic cl, input logic oc, input logic ack);
    @(negedge clk);
    on_phase = on; trip_cl = cl; trip_oc = oc; fault_ack = ack;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [5:0] len);
    @(negedge clk);
    rst = 1'b1; cfg_blank_len = len;
    on_phase = 0; trip_cl = 0; trip_oc = 0; fault_ack = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(6'd3);
    #1;
    chk("R1 term after reset", term_pulse, 1'b0);
    chk("R1 fault after reset", fault_req, 1'b0);
    chk("R1 blank after reset", blank_active, 1'b0);

    for (int i = 0; i < 18; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      chk($sformatf("R5 term row %0d", i), term_pulse, VEC[i][2]);
      chk($sformatf("R6 fault row %0d", i), fault_req, VEC[i][1]);
      chk($sformatf("R3 blank row %0d", i), blank_active, VEC[i][0]);
    end

    // R8: disable clears a pending fault and ignores trips
    step(1, 0, 0, 0);
    step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    chk("R6 fault set before disable", fault_req, 1'b1);
    @(negedge clk); enable = 1'b0;
    step(1, 1, 1, 0);
    chk("R8 fault cleared", fault_req, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 1, 0);
      chk("R8 term quiet", term_pulse, 1'b0);
      chk("R8 blank quiet", blank_active, 1'b0);
      chk("R8 fault quiet", fault_req, 1'b0);
    end

    // R7: blanking disabled
    @(negedge clk); enable = 1'b1; blank_en = 1'b0;
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R7 no blank when disabled", blank_active, 1'b0);
    step(1, 1, 0, 0);
    chk("R7 trip accepted at once", term_pulse, 1'b1);

    // R7 and R1: zero length captured at reset; later change ignored
    @(negedge clk); blank_en = 1'b1;
    do_reset(6'd0);
    @(negedge clk); cfg_blank_len = 6'd5;
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R7 zero length no blank", blank_active, 1'b0);
    chk("R1 length not reloaded", blank_active, 1'b0);
    step(1, 1, 1, 0);
    chk("R7 zero length term", term_pulse, 1'b1);
    chk("R10 zero length fault", fault_req, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule